// File: doc/BRIEF.md
# Coded-Coefficient Shift-and-Add Multiplier

This block is the multiply element of one tap in a reconfigurable transposed-form FIR filter. It does not hold the coefficient as a plain binary number. Instead, the coefficient is stored as a pre-analysed list of up to five operands. Each operand pairs a small multiple of the input with a programmable right shift. A separate sign bit and a presence mask complete the code. Software works out the code offline and writes it through a two-row write port. The block then multiplies every valid input sample by that coefficient.

A shared shift-and-add stage forms four multiples of the sample: x, x + x/2, x + x/4 and x + x/2 + x/4. Five selectors pick one multiple per operand, and five barrel shifters apply each operand's weight. A chain of adders accumulates the shifted terms. The mask picks which point of the chain feeds the output, so absent operands add nothing. A last stage negates the sum when the sign bit is set.

The result is exact and needs no rounding. The output LSB weighs 2^-17 of an input LSB, which means y_out equals x times the coefficient times 2^17. In integer terms, y_out = x · Σ m_k · 2^(15−d_k), where m_k is 4, 5, 6 or 7.

Top module: `coded_coef_mult`

## Requirements
- R1: While rst_n is low, and after it is released, out_valid and y_out read 0 and both code rows are cleared.
- R2: When wr_en is high on a clock edge, wr_data is written to the code row chosen by wr_row (0 = first row, 1 = second row). The new code applies to every sample accepted on a later edge.
- R3: A sample taken with in_valid high produces its result on y_out one clock later. out_valid equals in_valid delayed by one clock.
- R4: On a clock edge where in_valid is low, y_out keeps its previous value.
- R5: Each operand field is 6 bits: a 4-bit shift d in bits [5:2] and a 2-bit select code in bits [1:0]. The first row holds operand 1 in bits [17:12], operand 2 in bits [11:6] and operand 3 in bits [5:0]. The second row holds the sign in bit 17, operand 4 in bits [16:11], operand 5 in bits [10:5] and the mask in bits [4:0].
- R6: The select code 01 picks x, 10 picks x + x/2, 11 picks x + x/4 and 00 picks x + x/2 + x/4. These count as 4, 6, 5 and 7 quarters of x.
- R7: An operand with shift d contributes its multiple times 2^-d. The output is the exact two's-complement value x · Σ m_k · 2^(15−d_k), with no truncation.
- R8: Mask bit 4 marks operand 1 and mask bit 0 marks operand 5. Operand k counts only if its mask bit and the mask bits of every earlier operand are all set. The fields of operands that do not count have no effect on y_out, whatever they hold.
- R9: When the sign bit is 1, the accumulated sum is negated in two's complement.
- R10: When mask bit 4 is clear, every result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Code row write strobe |
| wr_row | input | 1 | Row select for the write (0 first, 1 second) |
| wr_data | input | 18 | Code row contents |
| in_valid | input | 1 | Input sample valid |
| x_in | input | 16 | Signed input sample |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| y_out | output | 38 | Signed product, LSB = 2^-17 of an input LSB |

## Verification
The assertions check on every cycle that out_valid is in_valid delayed by one, that y_out holds when no sample arrives, and that a zero input or a cleared first mask bit always gives a zero result. The bench scenarios are the only way to show the arithmetic itself. These cover the field positions, the four select codes, the shift weights, the mask-prefix rule with non-zero data in the skipped fields, and negation. The bench checks them against coefficients it encodes on its own and samples ranging from zero up to both extremes.

// File: rtl/coded_coef_mult.sv
module coded_coef_mult #(
  parameter int XW = 16,
  parameter int SW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_row,
  input  logic [3*(SW+2)-1:0]  wr_data,
  input  logic                 in_valid,
  input  logic [XW-1:0]        x_in,
  output logic                 out_valid,
  output logic [XW+2**SW+5:0]  y_out
);
  localparam int NOPS = 5;
  localparam int FW   = SW + 2;
  localparam int RW   = 3 * FW;
  localparam int MW   = XW + 3;
  localparam int OW   = XW + 2**SW + 6;

  logic [RW-1:0] row_a, row_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      row_a <= '0;
      row_b <= '0;
    end else if (wr_en) begin
      if (wr_row) row_b <= wr_data;
      else        row_a <= wr_data;
    end

  logic [FW-1:0] fld [NOPS];
  assign fld[0] = row_a[RW-1 -: FW];
  assign fld[1] = row_a[RW-1-FW -: FW];
  assign fld[2] = row_a[FW-1:0];
  assign fld[3] = row_b[RW-2 -: FW];
  assign fld[4] = row_b[RW-2-FW -: FW];

  wire             neg  = row_b[RW-1];
  wire [NOPS-1:0]  mask = row_b[NOPS-1:0];

  // multiples held in quarters of x so x/2 and x/4 stay exact
  logic signed [MW-1:0] xe, m4, m5, m6, m7;
  assign xe = MW'($signed(x_in));
  assign m4 = xe <<< 2;
  assign m6 = m4 + (xe <<< 1);
  assign m5 = m4 + xe;
  assign m7 = m6 + xe;

  logic signed [OW-1:0] term [NOPS];
  logic signed [OW-1:0] psum [NOPS];

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    logic signed [MW-1:0] sel;
    logic [SW-1:0]        d;
    assign d = fld[k][FW-1:2];
    always_comb
      case (fld[k][1:0])
        2'b01:   sel = m4;
        2'b10:   sel = m6;
        2'b11:   sel = m5;
        default: sel = m7;
      endcase
    assign term[k] = OW'(sel) <<< (~d);
    if (k == 0) begin : g_first
      assign psum[k] = term[k];
    end else begin : g_next
      assign psum[k] = psum[k-1] + term[k];
    end
  end

  logic signed [OW-1:0] picked;
  logic                 run;
  always_comb begin
    picked = '0;
    run    = 1'b1;
    for (int k = 0; k < NOPS; k++) begin
      run = run & mask[NOPS-1-k];
      if (run) picked = psum[k];
    end
  end

  wire signed [OW-1:0] result = neg ? -picked : picked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      y_out     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) y_out <= result;
    end
endmodule

module coded_coef_mult_chk #(
  parameter int XW = 16,
  parameter int OW = 38,
  parameter int RW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [XW-1:0] x_in,
  input logic          out_valid,
  input logic [OW-1:0] y_out,
  input logic [RW-1:0] row_b
);
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(y_out)); // R4
  AST_ZERO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(x_in) == '0) |-> (y_out == '0)); // R7
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && !$past(row_b[4])) |-> (y_out == '0)); // R10
endmodule

bind coded_coef_mult coded_coef_mult_chk #(.XW(XW), .OW(OW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
  .out_valid(out_valid), .y_out(y_out), .row_b(row_b)
);

// File: tb/test_coded_coef_mult.sv
`timescale 1ns/1ps
module test_coded_coef_mult;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic        wr_row = 0;
  logic [17:0] wr_data = '0;
  logic        in_valid = 0;
  logic [15:0] x_in = '0;
  logic        out_valid;
  logic [37:0] y_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  coded_coef_mult i_coded_coef_mult (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .in_valid(in_valid), .x_in(x_in), .out_valid(out_valid), .y_out(y_out)
  );

  function automatic longint mult_of(input logic [1:0] c);
    case (c)
      2'b01: return 4;
      2'b10: return 6;
      2'b11: return 5;
      default: return 7;
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [17:0] a, input logic [17:0] b);
    @(negedge clk); wr_en = 1; wr_row = 0; wr_data = a;
    @(negedge clk); wr_row = 1; wr_data = b;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  // applies one sample, checks R3 result and R4 hold on the following idle cycle
  task automatic apply(input logic [15:0] x, input longint exp, input string req);
    longint held;
    @(negedge clk); in_valid = 1; x_in = x;
    @(negedge clk); in_valid = 0; x_in = $urandom;
    check({req, " R3 valid"}, longint'(out_valid), 1);
    check(req, longint'($signed(y_out)), exp);
    held = longint'($signed(y_out));
    @(negedge clk);
    check("R4 hold", longint'($signed(y_out)), held);
    check("R3 valid low", longint'(out_valid), 0);
  endtask

  logic [15:0] xs [8];

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    xs[0] = 16'h0000; xs[1] = 16'h0001; xs[2] = 16'hFFFF; xs[3] = 16'h7FFF;
    xs[4] = 16'h8000; xs[5] = 16'h1234; xs[6] = 16'hC3A5; xs[7] = 16'h0F0F;

    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", longint'(out_valid), 0);
    check("R1 y_out in reset", longint'($signed(y_out)), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after reset", longint'(out_valid), 0);
    // R1 / R10: cleared rows mean an empty mask, so the product is zero
    apply(16'h4321, 0, "R1 R10 cleared code");

    // R6: each select code alone, shift 0, x = 1 -> multiple * 2^15
    for (int c = 0; c < 4; c++) begin
      load({4'd0, 2'(c), 12'd0}, {1'b0, 12'd0, 5'b10000});
      apply(16'd1, mult_of(2'(c)) <<< 15, "R6 select code");
    end

    // R7: each shift on operand 1 with code 01, x = 3
    for (int d = 0; d < 16; d++) begin
      load({4'(d), 2'b01, 12'd0}, {1'b0, 12'd0, 5'b10000});
      apply(16'd3, 3 * (longint'(4) <<< (15 - d)), "R7 shift weight");
    end

    // R5: distinct pattern in each field, all five present
    load({4'd0, 2'b01, 4'd2, 2'b10, 4'd5, 2'b11}, {1'b0, 4'd9, 2'b00, 4'd15, 2'b01, 5'b11111});
    apply(16'd7, 7 * ((4 <<< 15) + (6 <<< 13) + (5 <<< 10) + (7 <<< 6) + (4 <<< 0)), "R5 field layout");

    // R8: hole in mask, operands 4 and 5 carry data but must be skipped
    load({4'd1, 2'b01, 4'd3, 2'b00, 4'd7, 2'b10}, {1'b0, 4'd4, 2'b11, 4'd0, 2'b00, 5'b11010});
    apply(16'd5, 5 * ((4 <<< 14) + (7 <<< 12)), "R8 mask hole");

    // R10: first mask bit clear with other bits set
    load({4'd0, 2'b00, 4'd0, 2'b00, 4'd0, 2'b00}, {1'b1, 12'hFFF, 5'b01111});
    apply(16'h7FFF, 0, "R10 empty mask");

    // R9: sign negates
    load({4'd0, 2'b00, 12'd0}, {1'b1, 12'd0, 5'b10000});
    apply(16'h8000, -(-32768 * (longint'(7) <<< 15)), "R9 negate extreme");

    // sweep of software-encoded coefficients, 1 to 5 operands, unused fields garbage
    for (int t = 0; t < 60; t++) begin
      int n;
      logic s;
      logic [3:0] d [5];
      logic [1:0] c [5];
      logic [4:0] mask;
      longint coef;
      n = (t % 5) + 1;
      s = t[1];
      coef = 0;
      for (int k = 0; k < 5; k++) begin
        d[k] = 4'($urandom);
        c[k] = 2'($urandom);
        if (k < n) coef += mult_of(c[k]) <<< (15 - d[k]);
      end
      mask = 5'b11111 << (5 - n);
      if (t % 3 == 0 && n < 5) mask[4 - n - 1 + 1 - 1] = 1'b0;
      if (t % 4 == 0 && n < 4) mask[0] = 1'b1;
      load({d[0], c[0], d[1], c[1], d[2], c[2]}, {s, d[3], c[3], d[4], c[4], mask});
      for (int i = 0; i < 8; i++) begin
        longint xv;
        xv = longint'($signed(xs[i]));
        apply(xs[i], s ? -(xv * coef) : xv * coef, "R2 R5 R7 R8 R9 sweep");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule